// File: doc/BRIEF.md
# NAND Page Rule Keeper

This block models a small NAND-style storage array and enforces the rules such an array imposes on its user. A single command port takes read, program and erase commands. Each command carries a block address and a page address, and a program command also carries one page of data. The block records which pages have been written since their block was last cleared. It rejects any command that would break the rules, and a rejected command leaves the array untouched.

Erase works on a whole block and nothing smaller. Programming writes a full page at once, and a page can be written only once per erase. Within a block, pages must be written at ascending page numbers, although the caller may skip pages. Each command returns exactly one response that holds a two-bit status and, for reads, the page data. Each block also has a saturating erase counter, which can be read at any time through a separate lookup port.

Top module: `nand_rule_keeper`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0 and every erase count is 0. Every page reads as all ones with status OK.
- R2: An accepted erase (cmd_op 2) of an in-range block returns status 00. Afterwards every page of that block reads as all ones, and the block's order pointer returns to page 0. Other blocks are unaffected. The page field of an erase is ignored.
- R3: A program (cmd_op 1) of an unwritten page at or above the block's order pointer returns status 00. A later read (cmd_op 0) of that page returns the programmed data bit for bit.
- R4: A program of a page that has already been written since its block's last erase returns status 01, and the stored data is left unchanged.
- R5: A program of an unwritten page whose number is below the block's order pointer returns status 10, and the page stays unwritten.
- R6: A program may skip ahead to a higher page number. The order pointer then moves to one past the programmed page.
- R7: A block address at or above the block count, a page address at or above the page count on a read or program, or cmd_op 3 returns status 11. Nothing changes, and rsp_data is all ones.
- R8: A read of an in-range page that has not been written since its last erase returns all ones with status 00.
- R9: After an accepted program or erase that returns status 00, cmd_ready is low for exactly BUSY_CYCLES cycles. Reads and rejected commands leave cmd_ready high.
- R10: stat_erase_count combinationally shows the erase count of the block selected by stat_block, and 0 for an out-of-range block. Each successful erase adds one to the count, which holds at 2^ERASE_CNT_W-1.
- R11: A command is accepted on a clock edge where cmd_valid and cmd_ready are both high. rsp_valid is high for exactly the one cycle after each acceptance, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| cmd_block | input | BLK_W | Block address |
| cmd_page | input | PAGE_W | Page address |
| cmd_data | input | DATA_W | Page data for program |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 00 OK, 01 already written, 10 order violation, 11 out of range |
| rsp_data | output | DATA_W | Read data, all ones otherwise |
| stat_block | input | BLK_W | Block selected for erase count lookup |
| stat_erase_count | output | ERASE_CNT_W | Erase count of the selected block |

## Verification
Every piece of per-page and per-block state reaches the ports on the next command that touches it. A lost written flag shows as status 00 where 01 was due. A stale order pointer flips a status between 00 and 10 on the next program to that block. A wrong busy count shows at cmd_ready within BUSY_CYCLES cycles, and a bad erase count shows at once on the lookup port. For these reasons the bench runs a reference model and compares the ports on every cycle.

// File: rtl/nrk_pkg.sv
package nrk_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_REPROG = 2'd1,
        ST_ORDER  = 2'd2,
        ST_RANGE  = 2'd3
    } status_e;

    // Decide the outcome of one command from its address checks and page state
    function automatic status_e judge(
        input op_e  op,
        input logic blk_ok,
        input logic pg_ok,
        input logic written,
        input logic below_ptr
    );
        status_e s;
        unique case (op)
            OP_READ:  s = (blk_ok && pg_ok) ? ST_OK : ST_RANGE;
            OP_ERASE: s = blk_ok ? ST_OK : ST_RANGE;
            OP_PROG: begin
                if (!(blk_ok && pg_ok)) s = ST_RANGE;
                else if (written)       s = ST_REPROG;
                else if (below_ptr)     s = ST_ORDER;
                else                    s = ST_OK;
            end
            default:  s = ST_RANGE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nrk_busy_timer.sv
module nrk_busy_timer #(
    parameter int BUSY_CYCLES = 3,
    parameter int CW = (BUSY_CYCLES > 0) ? $clog2(BUSY_CYCLES + 1) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (start)        cnt_q <= CW'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign ready = (cnt_q == '0);

    generate
        if (BUSY_CYCLES > 0) begin : g_chk
            // R9
            start_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
                start |=> !ready);
            // R9
            no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
                !ready |-> !start);
        end
    endgenerate
endmodule

// File: rtl/nrk_page_store.sv
module nrk_page_store #(
    parameter int NUM_BLOCKS = 4,
    parameter int PAGES = 8,
    parameter int DATA_W = 16,
    parameter int BI_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    parameter int PI_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BI_W-1:0]   blk,
    input  logic [PI_W-1:0]   page,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [NUM_BLOCKS][PAGES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[blk][page] <= wr_data;
    end

    assign rd_data = mem_q[blk][page];
endmodule

// File: rtl/nrk_block_tracker.sv
module nrk_block_tracker #(
    parameter int NUM_BLOCKS = 4,
    parameter int PAGES = 8,
    parameter int CNT_W = 3,
    parameter int BI_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    parameter int PI_W = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             erase_en,
    input  logic             prog_en,
    input  logic [BI_W-1:0]  blk,
    input  logic [PI_W-1:0]  page,
    output logic             q_written,
    output logic [PI_W:0]    q_next,
    input  logic [BI_W-1:0]  stat_blk,
    output logic [CNT_W-1:0] stat_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [PAGES-1:0] written_q [NUM_BLOCKS];
    logic [PI_W:0]    next_q    [NUM_BLOCKS];
    logic [CNT_W-1:0] cnt_q     [NUM_BLOCKS];

    generate
        for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
            always_ff @(posedge clk) begin
                if (rst) begin
                    written_q[b] <= '0;
                    next_q[b]    <= '0;
                    cnt_q[b]     <= '0;
                end else if (erase_en && blk == BI_W'(b)) begin
                    written_q[b] <= '0;
                    next_q[b]    <= '0;
                    if (cnt_q[b] != CNT_MAX) cnt_q[b] <= cnt_q[b] + CNT_W'(1);
                end else if (prog_en && blk == BI_W'(b)) begin
                    written_q[b][page] <= 1'b1;
                    next_q[b]          <= {1'b0, page} + (PI_W+1)'(1);
                end
            end

            // R10
            cnt_hold_max_chk: assert property (@(posedge clk) disable iff (rst)
                (cnt_q[b] == CNT_MAX) |=> (cnt_q[b] == CNT_MAX));
        end
    endgenerate

    assign q_written = written_q[blk][page];
    assign q_next    = next_q[blk];
    assign stat_cnt  = cnt_q[stat_blk];

    // R2
    erase_resets_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        erase_en |=> (next_q[$past(blk)] == '0));
    // R5
    prog_only_legal_chk: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> (!written_q[blk][page] && ({1'b0, page} >= next_q[blk])));
endmodule

// File: rtl/nand_rule_keeper.sv
module nand_rule_keeper
    import nrk_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int PAGES = 8,
    parameter int DATA_W = 16,
    parameter int BUSY_CYCLES = 3,
    parameter int ERASE_CNT_W = 3,
    parameter int BLK_W = $clog2(NUM_BLOCKS) + 1,
    parameter int PAGE_W = $clog2(PAGES) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [BLK_W-1:0]       cmd_block,
    input  logic [PAGE_W-1:0]      cmd_page,
    input  logic [DATA_W-1:0]      cmd_data,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_status,
    output logic [DATA_W-1:0]      rsp_data,
    input  logic [BLK_W-1:0]       stat_block,
    output logic [ERASE_CNT_W-1:0] stat_erase_count
);
    localparam int BI_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
    localparam int PI_W = (PAGES > 1) ? $clog2(PAGES) : 1;

    op_e               op;
    status_e           verdict;
    logic              accept, blk_ok, pg_ok, below;
    logic              prog_en, erase_en;
    logic [BI_W-1:0]   blk_idx;
    logic [PI_W-1:0]   pg_idx;
    logic              q_written;
    logic [PI_W:0]     q_next;
    logic [DATA_W-1:0] store_rd;
    logic [ERASE_CNT_W-1:0] stat_raw;

    assign op      = op_e'(cmd_op);
    assign accept  = cmd_valid && cmd_ready;
    assign blk_ok  = cmd_block < BLK_W'(NUM_BLOCKS);
    assign pg_ok   = cmd_page < PAGE_W'(PAGES);
    assign blk_idx = cmd_block[BI_W-1:0];
    assign pg_idx  = cmd_page[PI_W-1:0];
    assign below   = {1'b0, pg_idx} < q_next;
    assign verdict = judge(op, blk_ok, pg_ok, q_written, below);

    assign prog_en  = accept && (op == OP_PROG)  && (verdict == ST_OK);
    assign erase_en = accept && (op == OP_ERASE) && (verdict == ST_OK);

    nrk_block_tracker #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .CNT_W(ERASE_CNT_W),
        .BI_W(BI_W), .PI_W(PI_W)
    ) i_tracker (
        .clk(clk), .rst(rst),
        .erase_en(erase_en), .prog_en(prog_en),
        .blk(blk_idx), .page(pg_idx),
        .q_written(q_written), .q_next(q_next),
        .stat_blk(stat_block[BI_W-1:0]), .stat_cnt(stat_raw)
    );

    nrk_page_store #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES(PAGES), .DATA_W(DATA_W),
        .BI_W(BI_W), .PI_W(PI_W)
    ) i_store (
        .clk(clk), .wr_en(prog_en),
        .blk(blk_idx), .page(pg_idx),
        .wr_data(cmd_data), .rd_data(store_rd)
    );

    nrk_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk(clk), .rst(rst),
        .start(prog_en || erase_en),
        .ready(cmd_ready)
    );

    assign stat_erase_count = (stat_block < BLK_W'(NUM_BLOCKS)) ? stat_raw : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_data   <= '1;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_status <= verdict;
                rsp_data   <= (op == OP_READ && verdict == ST_OK && q_written) ? store_rd : '1;
            end
        end
    end

    // R11
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);
    // R11
    no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rsp_valid);
    // R9
    reject_keeps_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_OK) |-> cmd_ready);
    // R7
    range_data_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_RANGE) |-> (rsp_data == '1));
endmodule

// File: tb/test_nand_rule_keeper.sv
module test_nand_rule_keeper;
    localparam int NB = 4, PG = 8, DW = 16, BUSY = 3, CW = 3;
    localparam int BW = 3, PW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [BW-1:0] cmd_block = '0;
    logic [PW-1:0] cmd_page = '0;
    logic [DW-1:0] cmd_data = '0;
    logic rsp_valid;
    logic [1:0] rsp_status;
    logic [DW-1:0] rsp_data;
    logic [BW-1:0] stat_block = '0;
    logic [CW-1:0] stat_erase_count;

    int errors = 0, checks = 0, cyc_n = 0;

    always #5 clk = ~clk;

    nand_rule_keeper #(.NUM_BLOCKS(NB), .PAGES(PG), .DATA_W(DW),
        .BUSY_CYCLES(BUSY), .ERASE_CNT_W(CW)) i_nand_rule_keeper (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_block(cmd_block), .cmd_page(cmd_page),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_data(rsp_data), .stat_block(stat_block),
        .stat_erase_count(stat_erase_count));

    // Behavioural reference model
    int mem [NB][PG];
    bit wr  [NB][PG];
    int nxt [NB];
    int ecnt[NB];
    int busy = 0;
    bit m_ready = 1, m_rv = 0, m_acc = 0;
    int m_st = 0, m_data = 'hFFFF;

    always @(posedge clk) begin
        if (rst) begin
            foreach (wr[b, p]) wr[b][p] = 0;
            foreach (nxt[b]) begin nxt[b] = 0; ecnt[b] = 0; end
            busy = 0; m_rv = 0; m_acc = 0;
        end else begin
            int b, p;
            b = int'(cmd_block); p = int'(cmd_page);
            m_acc = cmd_valid && (busy == 0);
            if (busy > 0) busy--;
            m_rv = m_acc;
            if (m_acc) begin
                m_data = 'hFFFF;
                if (cmd_op == 2'd3 || b >= NB || (cmd_op != 2'd2 && p >= PG)) m_st = 3;
                else if (cmd_op == 2'd0) begin
                    m_st = 0;
                    if (wr[b][p]) m_data = mem[b][p];
                end else if (cmd_op == 2'd2) begin
                    m_st = 0;
                    for (int i = 0; i < PG; i++) wr[b][i] = 0;
                    nxt[b] = 0;
                    if (ecnt[b] < (1 << CW) - 1) ecnt[b]++;
                    busy = BUSY;
                end else if (wr[b][p]) m_st = 1;
                else if (p < nxt[b]) m_st = 2;
                else begin
                    m_st = 0; wr[b][p] = 1; mem[b][p] = int'(cmd_data);
                    nxt[b] = p + 1; busy = BUSY;
                end
            end
        end
        m_ready = (busy == 0);
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string st_tag(input int s);
        case (s)
            1: return "R4";
            2: return "R5";
            3: return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic check_all();
        int sb, se;
        chk(cmd_ready == m_ready, "R9", "cmd_ready", int'(cmd_ready), int'(m_ready));
        chk(rsp_valid == m_rv, "R11", "rsp_valid", int'(rsp_valid), int'(m_rv));
        if (m_rv) begin
            chk(int'(rsp_status) == m_st, st_tag(m_st), "rsp_status", int'(rsp_status), m_st);
            chk(int'(rsp_data) == m_data, "R3", "rsp_data", int'(rsp_data), m_data);
        end
        sb = int'(stat_block);
        se = (sb < NB) ? ecnt[sb] : 0;
        chk(int'(stat_erase_count) == se, "R10", "stat_erase_count", int'(stat_erase_count), se);
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); check_all(); end
    endtask

    task automatic send(input int op, input int b, input int p, input int d);
        cmd_op = 2'(op); cmd_block = BW'(b); cmd_page = PW'(p);
        cmd_data = DW'(d); cmd_valid = 1'b1;
        do begin @(negedge clk); check_all(); end while (!m_acc);
        cmd_valid = 1'b0;
    endtask

    task automatic expect_rsp(input int st, input int d, input string tag);
        chk(rsp_valid == 1'b1, tag, "rsp_valid", int'(rsp_valid), 1);
        chk(int'(rsp_status) == st, tag, "status", int'(rsp_status), st);
        chk(int'(rsp_data) == d, tag, "data", int'(rsp_data), d);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 20000) begin
            errors++; checks++;
            $display("FAIL R11: watchdog actual=%0d expected<=20000", cyc_n);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
        for (int b = 0; b < NB; b++) begin
            stat_block = BW'(b); #1;
            chk(stat_erase_count == '0, "R1", "erase count after reset", int'(stat_erase_count), 0);
        end
        send(0, 0, 0, 0);  expect_rsp(0, 'hFFFF, "R1");

        // R3 program then read
        send(1, 0, 0, 'hA5C3); expect_rsp(0, 'hFFFF, "R3");
        chk(cmd_ready == 1'b0, "R9", "ready low after program", int'(cmd_ready), 0);
        send(0, 0, 0, 0);  expect_rsp(0, 'hA5C3, "R3");
        // R4 second write to same page
        send(1, 0, 0, 'h1111); expect_rsp(1, 'hFFFF, "R4");
        chk(cmd_ready == 1'b1, "R9", "ready after reject", int'(cmd_ready), 1);
        send(0, 0, 0, 0);  expect_rsp(0, 'hA5C3, "R4");
        // R6 skip ahead, R5 order violation, R8 unwritten read
        send(1, 0, 3, 'h3333); expect_rsp(0, 'hFFFF, "R6");
        send(1, 0, 1, 'h4444); expect_rsp(2, 'hFFFF, "R5");
        send(1, 0, 2, 'h5555); expect_rsp(2, 'hFFFF, "R5");
        send(0, 0, 1, 0);  expect_rsp(0, 'hFFFF, "R8");
        send(1, 0, 4, 'h6666); expect_rsp(0, 'hFFFF, "R6");
        send(0, 0, 3, 0);  expect_rsp(0, 'h3333, "R6");
        // R7 range and reserved op
        send(0, 4, 0, 0);  expect_rsp(3, 'hFFFF, "R7");
        send(1, 1, 8, 'h7777); expect_rsp(3, 'hFFFF, "R7");
        send(2, 5, 0, 0);  expect_rsp(3, 'hFFFF, "R7");
        send(3, 1, 0, 'h8888); expect_rsp(3, 'hFFFF, "R7");
        send(0, 1, 0, 0);  expect_rsp(0, 'hFFFF, "R7");
        send(1, 1, 0, 'h9999); expect_rsp(0, 'hFFFF, "R7");
        // R2 erase
        send(2, 0, 6, 0);  expect_rsp(0, 'hFFFF, "R2");
        idle(4);
        send(0, 0, 0, 0);  expect_rsp(0, 'hFFFF, "R2");
        send(0, 0, 3, 0);  expect_rsp(0, 'hFFFF, "R2");
        send(0, 1, 0, 0);  expect_rsp(0, 'h9999, "R2");
        send(1, 0, 0, 'hBEEF); expect_rsp(0, 'hFFFF, "R2");
        send(0, 0, 0, 0);  expect_rsp(0, 'hBEEF, "R2");
        stat_block = 3'd0; #1;
        chk(stat_erase_count == 3'd1, "R10", "count after one erase", int'(stat_erase_count), 1);
        // R10 saturation
        for (int i = 0; i < 9; i++) send(2, 2, 0, 0);
        idle(5);
        stat_block = 3'd2; #1;
        chk(stat_erase_count == 3'd7, "R10", "saturated count", int'(stat_erase_count), 7);
        stat_block = 3'd6; #1;
        chk(stat_erase_count == 3'd0, "R10", "out-of-range lookup", int'(stat_erase_count), 0);
        // R11 back-to-back reads keep ready high
        send(0, 1, 0, 0);
        send(0, 1, 0, 0);  expect_rsp(0, 'h9999, "R11");
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule